// File: doc/BRIEF.md
# UART Single-Character Receive Holding Stage

This block sits after a UART deserializer that has no FIFO. Each finished character arrives on a one-cycle strobe together with its byte and two error indications (bad stop bit, bad parity). The block keeps that byte in a single holding register and raises a ready flag. It also keeps sticky flags for framing, parity and overrun, plus a summary error flag.

Software sees the block through a small read port with two addresses. One is a status register and the other is the data register. Reads have side effects. A status read arms an internal marker. A data read clears the ready flag, the summary flag and the framing and parity flags. A data read normally clears the overrun flag as well. There is one exception. If a new character overwrote the holding register after the status read and before the data read, the overrun flag survives the data read, and that overrun never raises the summary flag. Software can therefore catch this late overrun by checking the status register again after the data read.

An error-accept control decides what happens to a character that arrives with a framing or parity error. When the control is clear, that character is not loaded and does not set ready, although its error flags are still recorded. The interrupt output is the ready flag gated by an enable input.

Top module: `uart_rxbuf`

## Requirements
- R1: The summary error flag (status bit 4) is set when an arriving character carries a framing error or a parity error, or when it overruns the holding register while no status read is pending since the last data read.
- R2: A data read clears the summary, framing (status bit 1) and parity (status bit 2) flags, unless a new character arrives in the same cycle.
- R3: Address 1 is the data register and address 0 is the status register. A data read returns the held byte, and the ready flag reads 0 from the next cycle on.
- R4: An overrun that happens after a status read and before the next data read keeps the overrun flag (status bit 3) set through that data read. The next data read then clears it.
- R5: An overrun that happens after a status read and before the next data read does not set the summary flag.
- R6: An accepted character is loaded into the holding register and sets the ready flag (status bit 0). Status bits 7..5 read 0.
- R7: A character accepted while ready is set, with no data read in the same cycle, replaces the held byte and sets the overrun flag.
- R8: While error-accept is low, a character with a framing or parity error neither loads the holding register nor sets ready. Its framing and parity flags and the summary flag are still set.
- R9: The interrupt output equals the ready flag AND the receive-interrupt enable input.
- R10: A synchronous reset clears the held byte, all flags and the status-read marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| char_valid | input | 1 | One-cycle strobe for a completed character |
| char_data | input | 8 | Received byte |
| char_ferr | input | 1 | Framing error for this character |
| char_perr | input | 1 | Parity error for this character |
| err_accept | input | 1 | 1: erroneous characters are still loaded and set ready |
| rx_int_en | input | 1 | Receive interrupt enable |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 1 | 0 = status, 1 = data |
| rd_data | output | 8 | Read value, valid in the cycle of rd_en |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The hardest case to reach is a character that arrives between a status read and the data read that follows it. Only this timing separates a surviving overrun from one that clears, and a silent summary flag from a raised one. The stimulus reads status, then sends a character, then reads data, and repeats the sequence with a second overrun placed before the status read. This shows that an overrun seen before the status read still raises the summary flag and clears on the data read. Status is read again after each data read to check whether overrun was left set.

// File: rtl/uart_rxbuf_pkg.sv
package uart_rxbuf_pkg;
  localparam int STAT_W = 8;
  localparam int BIT_RDY = 0;
  localparam int BIT_FE  = 1;
  localparam int BIT_PE  = 2;
  localparam int BIT_OE  = 3;
  localparam int BIT_ERR = 4;
  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  typedef struct packed {
    logic rdy;
    logic fe;
    logic pe;
    logic oe;
    logic err;
  } rx_flags_t;

  function automatic logic f_accept(input logic valid, input logic fe,
                                    input logic pe, input logic err_ok);
    return valid && (err_ok || !(fe || pe));
  endfunction

  function automatic logic [STAT_W-1:0] f_pack(input rx_flags_t f);
    logic [STAT_W-1:0] s;
    s = '0;
    s[BIT_RDY] = f.rdy;
    s[BIT_FE]  = f.fe;
    s[BIT_PE]  = f.pe;
    s[BIT_OE]  = f.oe;
    s[BIT_ERR] = f.err;
    return s;
  endfunction
endpackage

// File: rtl/uart_rxbuf_event.sv
module uart_rxbuf_event (
  input  logic char_valid,
  input  logic char_ferr,
  input  logic char_perr,
  input  logic err_accept,
  input  logic rdy_q,
  input  logic data_rd,
  input  logic mark_q,
  output logic accept,
  output logic ovr_evt,
  output logic ovr_late
);
  import uart_rxbuf_pkg::*;

  always_comb begin
    accept   = f_accept(char_valid, char_ferr, char_perr, err_accept);
    ovr_evt  = accept && rdy_q && !data_rd;
    ovr_late = ovr_evt && mark_q;
  end
endmodule

// File: rtl/uart_rxbuf_flags.sv
module uart_rxbuf_flags (
  input  logic clk,
  input  logic rst,
  input  logic char_valid,
  input  logic char_ferr,
  input  logic char_perr,
  input  logic accept,
  input  logic ovr_evt,
  input  logic ovr_late,
  input  logic data_rd,
  input  logic stat_rd,
  output uart_rxbuf_pkg::rx_flags_t flags_q,
  output logic mark_q,
  output logic late_q
);
  import uart_rxbuf_pkg::*;

  rx_flags_t base, nxt;
  logic      late_base;

  always_comb begin
    base      = flags_q;
    late_base = late_q;
    if (data_rd) begin
      base.rdy  = 1'b0;
      base.fe   = 1'b0;
      base.pe   = 1'b0;
      base.err  = 1'b0;
      base.oe   = late_q;
      late_base = 1'b0;
    end
    nxt      = base;
    nxt.rdy  = base.rdy | accept;
    nxt.fe   = base.fe  | (char_valid & char_ferr);
    nxt.pe   = base.pe  | (char_valid & char_perr);
    nxt.oe   = base.oe  | ovr_evt;
    nxt.err  = base.err | (char_valid & (char_ferr | char_perr))
                        | (ovr_evt & !ovr_late);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      mark_q  <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      flags_q <= nxt;
      late_q  <= late_base | ovr_late;
      if (data_rd)      mark_q <= 1'b0;
      else if (stat_rd) mark_q <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rxbuf_hold.sv
module uart_rxbuf_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/uart_rxbuf.sv
module uart_rxbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_ferr,
  input  logic              char_perr,
  input  logic              err_accept,
  input  logic              rx_int_en,
  input  logic              rd_en,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_irq
);
  import uart_rxbuf_pkg::*;

  localparam int OUT_W = (DATA_W > STAT_W) ? DATA_W : STAT_W;

  rx_flags_t         flags_q;
  logic              mark_q, late_q;
  logic              accept, ovr_evt, ovr_late;
  logic              data_rd, stat_rd;
  logic [DATA_W-1:0] hold_q;
  logic [OUT_W-1:0]  stat_ext;

  assign data_rd = rd_en && (rd_addr == ADDR_DATA);
  assign stat_rd = rd_en && (rd_addr == ADDR_STAT);

  uart_rxbuf_event u_event (
    .char_valid(char_valid), .char_ferr(char_ferr), .char_perr(char_perr),
    .err_accept(err_accept), .rdy_q(flags_q.rdy), .data_rd(data_rd),
    .mark_q(mark_q), .accept(accept), .ovr_evt(ovr_evt), .ovr_late(ovr_late)
  );

  uart_rxbuf_flags u_flags (
    .clk(clk), .rst(rst), .char_valid(char_valid), .char_ferr(char_ferr),
    .char_perr(char_perr), .accept(accept), .ovr_evt(ovr_evt),
    .ovr_late(ovr_late), .data_rd(data_rd), .stat_rd(stat_rd),
    .flags_q(flags_q), .mark_q(mark_q), .late_q(late_q)
  );

  uart_rxbuf_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .load(accept), .din(char_data), .dout(hold_q)
  );

  assign stat_ext = OUT_W'(f_pack(flags_q));

  always_comb begin
    rd_data = '0;
    if (data_rd)      rd_data = hold_q;
    else if (stat_rd) rd_data = stat_ext[DATA_W-1:0];
  end

  assign rx_irq = flags_q.rdy && rx_int_en;
endmodule

// File: rtl/uart_rxbuf_chk.sv
module uart_rxbuf_chk (
  input logic clk,
  input logic rst,
  input logic char_valid,
  input logic char_ferr,
  input logic char_perr,
  input logic err_accept,
  input logic rx_int_en,
  input logic rx_irq,
  input logic accept,
  input logic data_rd,
  input logic rdy,
  input logic fe,
  input logic pe,
  input logic oe,
  input logic err,
  input logic late
);
  AST_SUMMARY_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err |-> (fe || pe || oe)); // R1
  AST_DATA_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    data_rd && !char_valid |=> !rdy && !fe && !pe && !err); // R2
  AST_LATE_OVERRUN_KEPT: assert property (@(posedge clk) disable iff (rst)
    data_rd && late && !char_valid |=> oe && !err); // R4
  AST_ACCEPT_READY: assert property (@(posedge clk) disable iff (rst)
    accept |=> rdy); // R6
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
    accept && rdy && !data_rd |=> oe); // R7
  AST_REJECT_NO_READY: assert property (@(posedge clk) disable iff (rst)
    char_valid && !err_accept && (char_ferr || char_perr) && !rdy |=> !rdy); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !rx_int_en |-> !rx_irq); // R9
endmodule

bind uart_rxbuf uart_rxbuf_chk u_chk (
  .clk(clk), .rst(rst), .char_valid(char_valid), .char_ferr(char_ferr),
  .char_perr(char_perr), .err_accept(err_accept), .rx_int_en(rx_int_en),
  .rx_irq(rx_irq), .accept(accept), .data_rd(data_rd),
  .rdy(flags_q.rdy), .fe(flags_q.fe), .pe(flags_q.pe), .oe(flags_q.oe),
  .err(flags_q.err), .late(late_q)
);

// File: tb/uart_rxbuf_tb.sv
module uart_rxbuf_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       char_valid = 1'b0;
  logic [7:0] char_data = '0;
  logic       char_ferr = 1'b0, char_perr = 1'b0;
  logic       err_accept = 1'b1, rx_int_en = 1'b1;
  logic       rd_en = 1'b0, rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       rx_irq;

  int n_cmp = 0, n_bad = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  uart_rxbuf u_dut (
    .clk(clk), .rst(rst), .char_valid(char_valid), .char_data(char_data),
    .char_ferr(char_ferr), .char_perr(char_perr), .err_accept(err_accept),
    .rx_int_en(rx_int_en), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rx_irq(rx_irq)
  );

  always #5 clk = ~clk;

  // status layout: bit0 ready, bit1 framing, bit2 parity, bit3 overrun, bit4 summary
  function automatic logic [7:0] st(input logic r, input logic f, input logic p,
                                    input logic o, input logic e);
    return {3'b000, e, o, p, f, r};
  endfunction

  // monitor: pops the expected value for each read, samples between edges
  always @(negedge clk) begin
    if (rd_en && !rst) begin
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty: actual %02h expected none", rd_data);
      end else begin
        item_t it;
        it = sb.pop_front();
        n_cmp++;
        if (rd_data !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %02h expected %02h", it.tag, rd_data, it.exp);
        end
      end
    end
  end

  task automatic send(input logic [7:0] d, input logic f, input logic p);
    @(posedge clk); #1;
    char_valid = 1'b1; char_data = d; char_ferr = f; char_perr = p;
    @(posedge clk); #1;
    char_valid = 1'b0; char_ferr = 1'b0; char_perr = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    n_cmp++;
    if (rx_irq !== exp) begin
      n_bad++;
      $display("FAIL %s: actual irq %0b expected %0b", tag, rx_irq, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    rd(1'b0, 8'h00, "R10 reset status");
    rd(1'b1, 8'h00, "R10 reset data");
    chk_irq(1'b0, "R10 reset irq");

    send(8'hA5, 0, 0);
    chk_irq(1'b1, "R9 irq on ready");
    rd(1'b0, st(1,0,0,0,0), "R6 ready after char");
    rd(1'b1, 8'hA5, "R3 data byte");
    rd(1'b0, 8'h00, "R3 ready cleared");

    send(8'h3C, 1, 0);
    rd(1'b0, st(1,1,0,0,1), "R1 framing sets summary");
    rd(1'b1, 8'h3C, "R3 data with error");
    rd(1'b0, 8'h00, "R2 flags cleared");

    send(8'h11, 0, 1);
    rd(1'b0, st(1,0,1,0,1), "R1 parity sets summary");
    rd(1'b1, 8'h11, "R3 parity data");

    send(8'h22, 0, 0);
    send(8'h33, 0, 0);
    rd(1'b0, st(1,0,0,1,1), "R7 visible overrun");
    rd(1'b1, 8'h33, "R7 newest byte kept");
    rd(1'b0, 8'h00, "R4 visible overrun clears");

    send(8'h44, 0, 0);
    rd(1'b0, st(1,0,0,0,0), "R6 before late overrun");
    send(8'h55, 0, 0);
    rd(1'b1, 8'h55, "R7 late overwrite data");
    rd(1'b0, st(0,0,0,1,0), "R5 late overrun no summary");
    rd(1'b1, 8'h55, "R4 buffer unchanged");
    rd(1'b0, 8'h00, "R4 late overrun clears next read");

    send(8'h66, 0, 0);
    rd(1'b0, st(1,0,0,0,0), "R6 first status");
    send(8'h77, 0, 0);
    rd(1'b0, st(1,0,0,1,0), "R5 status shows late overrun");
    rd(1'b1, 8'h77, "R3 data after late");
    rd(1'b0, st(0,0,0,1,0), "R4 overrun survives");
    rd(1'b1, 8'h77, "R3 data reread");
    rd(1'b0, 8'h00, "R4 cleared");

    err_accept = 1'b0;
    send(8'h88, 0, 1);
    chk_irq(1'b0, "R8 rejected no irq");
    rd(1'b0, st(0,0,1,0,1), "R8 flags recorded not ready");
    rd(1'b1, 8'h77, "R8 buffer not loaded");
    rd(1'b0, 8'h00, "R2 cleared after reject");
    send(8'h99, 0, 0);
    rd(1'b0, st(1,0,0,0,0), "R8 clean char accepted");
    rd(1'b1, 8'h99, "R8 clean data");
    err_accept = 1'b1;

    rx_int_en = 1'b0;
    send(8'hC3, 0, 0);
    chk_irq(1'b0, "R9 irq masked");
    rx_int_en = 1'b1;
    chk_irq(1'b1, "R9 irq unmasked");
    rd(1'b1, 8'hC3, "R3 masked data");
    chk_irq(1'b0, "R9 irq drops after read");

    send(8'h5A, 0, 0);
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    rd(1'b0, 8'h00, "R10 reset clears flags");
    rd(1'b1, 8'h00, "R10 reset clears byte");

    repeat (2) @(posedge clk);
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule